// File: doc/BRIEF.md
# Double-Pumped CPU/Video Memory Arbiter

This block shares one 16-bit asynchronous SRAM between a processor and a video scanout engine. It runs from a fast clock at `SUB` times the processor clock; `SUB` is 4 by default. Time is cut into a repeating period of 8 processor clocks. The first 4 processor clocks form the processor turn and the last 4 form the video turn. The result is a strict 50/50 split of memory time.

In the video turn the arbiter makes two back-to-back 16-bit reads at consecutive word addresses. It hands the scanout one 32-bit word with the first word in the upper half. At an 8.125 MHz processor clock, this gives 32 pixels per period at about 1.016 MHz, which is an effective pixel rate four times the processor clock.

The processor side uses a held request. The arbiter samples it only at the last fast clock before a processor turn. It then performs at most one access (read, or write with byte lanes) and signals completion with a ready pulse. A frame-start pulse rewinds the video address counter to a base address.

Top module: `double_pump_arbiter`

## Requirements
- R1: While reset is asserted, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are high and `cpu_ack`, `cpu_ready` and `vid_valid` are low. After release, the video address counter holds `VBASE`.
- R2: Counting fast clocks from reset release, phase = count mod 8·SUB. Phases 0 to 4·SUB−1 are the processor turn and the rest are the video turn. In the video turn the SRAM is enabled with `sram_we_n` high throughout. `sram_we_n` is never low outside the processor turn.
- R3: A video turn reads word A in its first half and word A+1 in its second half. `vid_data` = {mem[A], mem[A+1]}, with mem[A] in bits 31:16. `vid_addr` = A. `vid_valid` pulses for exactly the phase-0 cycle that follows each video turn.
- R4: A advances by 2 per video turn, modulo 2^AW.
- R5: After a `frame_start` pulse during a processor turn, the next video turn reads from `VBASE`. After a pulse during a video turn, the current turn completes unchanged and the turn after it reads from `VBASE`.
- R6: `cpu_req` is sampled at phase 8·SUB−1. If it is high, `cpu_ack` pulses at phase 0. The address, write flag, byte enables and write data are captured at that sampling edge, and later changes to them have no effect. `cpu_ready` pulses at phase 2·SUB. For a read, `cpu_rdata` holds the addressed word from that cycle onwards.
- R7: A request raised during a video turn at phase p is acknowledged 8·SUB−p fast clocks later, which is never more than one turn.
- R8: A write stores `cpu_wdata[15:8]` only if `cpu_be[1]` is set, and `cpu_wdata[7:0]` only if `cpu_be[0]` is set. With both bits clear, memory is unchanged.
- R9: Each access lasts 2·SUB fast clocks. Its first fast clock is a setup cycle with both strobes high. `sram_we_n` and `sram_oe_n` are never low together.
- R10: In a processor turn without an acknowledge, and in the second half of every processor turn, `sram_ce_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, SUB times the processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_be | input | 2 | Byte lanes for writes: bit 1 upper, bit 0 lower |
| cpu_addr | input | AW | Processor word address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_ack | output | 1 | One-cycle pulse when the request is taken |
| cpu_ready | output | 1 | One-cycle pulse when the access completes |
| cpu_rdata | output | 16 | Read data, valid from the ready pulse |
| frame_start | input | 1 | Rewinds the video address to VBASE |
| vid_valid | output | 1 | One-cycle pulse when a new video word is available |
| vid_addr | output | AW | Word address of the upper half of vid_data |
| vid_data | output | 32 | Two fetched words, first one in bits 31:16 |
| sram_addr | output | AW | SRAM word address |
| sram_dout | output | 16 | SRAM write data |
| sram_din | input | 16 | SRAM read data |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_we_n | output | 1 | SRAM write strobe, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_ub_n | output | 1 | SRAM upper byte enable, active low |
| sram_lb_n | output | 1 | SRAM lower byte enable, active low |

## Verification
The properties assume a requester that keeps `cpu_req` high until it sees `cpu_ready` and drops it in the same processor turn. Otherwise a second access would follow in the next period. The properties also assume a combinational SRAM whose read data settles within the strobed cycles of an access. The bench's SRAM model answers in the same cycle as the address. Its request driver releases `cpu_req` on the ready cycle and pulses `frame_start` for single cycles at chosen phases. The address-step property is suspended for two periods after any `frame_start`.

// File: rtl/double_pump_arbiter.sv
module double_pump_arbiter #(
  parameter int unsigned AW    = 18,
  parameter int unsigned SUB   = 4,
  parameter int unsigned VBASE = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [1:0]    cpu_be,
  input  logic [AW-1:0] cpu_addr,
  input  logic [15:0]   cpu_wdata,
  output logic          cpu_ack,
  output logic          cpu_ready,
  output logic [15:0]   cpu_rdata,
  input  logic          frame_start,
  output logic          vid_valid,
  output logic [AW-1:0] vid_addr,
  output logic [31:0]   vid_data,
  output logic [AW-1:0] sram_addr,
  output logic [15:0]   sram_dout,
  input  logic [15:0]   sram_din,
  output logic          sram_ce_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic          sram_ub_n,
  output logic          sram_lb_n
);
  localparam int unsigned ACC  = 2 * SUB;
  localparam int unsigned TURN = 2 * ACC;
  localparam int unsigned PER  = 2 * TURN;
  localparam int unsigned PW   = $clog2(PER);

  logic [PW-1:0] phase;
  logic          c_act, c_we;
  logic [1:0]    c_be;
  logic [AW-1:0] c_addr, vcnt;
  logic [15:0]   c_wdata, vhi;
  logic          fs_pend;

  wire          in_v   = phase >= PW'(TURN);
  wire [PW-1:0] tph    = in_v ? phase - PW'(TURN) : phase;
  wire          second = tph >= PW'(ACC);
  wire [PW-1:0] slot   = second ? tph - PW'(ACC) : tph;
  wire          setup  = slot == '0;
  wire          lastc  = slot == PW'(ACC - 1);
  wire          plast  = phase == PW'(PER - 1);
  wire          cpu_on = !in_v && !second && c_act;

  assign sram_ce_n = !(in_v || cpu_on);
  assign sram_addr = in_v ? vcnt + AW'(second) : c_addr;
  assign sram_dout = c_wdata;
  assign sram_oe_n = !((in_v || (cpu_on && !c_we)) && !setup);
  assign sram_we_n = !(cpu_on && c_we && !setup && !lastc);
  assign sram_ub_n = !(in_v || (cpu_on && (!c_we || c_be[1])));
  assign sram_lb_n = !(in_v || (cpu_on && (!c_we || c_be[0])));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= '0;
      c_act     <= 1'b0;
      c_we      <= 1'b0;
      c_be      <= 2'b00;
      c_addr    <= '0;
      c_wdata   <= '0;
      cpu_ack   <= 1'b0;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      phase     <= plast ? '0 : phase + 1'b1;
      cpu_ack   <= plast && cpu_req;
      cpu_ready <= cpu_on && lastc;
      if (plast) begin
        c_act <= cpu_req;
        if (cpu_req) begin
          c_we    <= cpu_we;
          c_be    <= cpu_be;
          c_addr  <= cpu_addr;
          c_wdata <= cpu_wdata;
        end
      end
      if (cpu_on && lastc && !c_we) cpu_rdata <= sram_din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt      <= AW'(VBASE);
      fs_pend   <= 1'b0;
      vhi       <= '0;
      vid_valid <= 1'b0;
      vid_addr  <= '0;
      vid_data  <= '0;
    end else begin
      vid_valid <= in_v && second && lastc;
      if (in_v && !second && lastc) vhi <= sram_din;
      if (in_v && second && lastc) begin
        vid_data <= {vhi, sram_din};
        vid_addr <= vcnt;
      end
      if (plast) begin
        vcnt    <= (fs_pend || frame_start) ? AW'(VBASE) : vcnt + AW'(2);
        fs_pend <= 1'b0;
      end else if (frame_start) begin
        if (in_v) fs_pend <= 1'b1;
        else      vcnt    <= AW'(VBASE);
      end
    end
  end
endmodule

// File: rtl/double_pump_arbiter_props.sv
module double_pump_arbiter_props #(
  parameter int unsigned AW  = 18,
  parameter int unsigned SUB = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          sram_we_n,
  input logic                          sram_oe_n,
  input logic                          cpu_ack,
  input logic                          cpu_ready,
  input logic                          vid_valid,
  input logic [AW-1:0]                 vid_addr,
  input logic                          frame_start,
  input logic [$clog2(16*SUB)-1:0]     phase
);
  localparam int unsigned ACC  = 2 * SUB;
  localparam int unsigned TURN = 2 * ACC;
  localparam int unsigned PER  = 2 * TURN;
  localparam int unsigned CW   = $clog2(PER) + 2;
  localparam int unsigned SAT  = 2 * PER;

  logic [CW-1:0] since_ack, fs_age;
  logic [AW-1:0] prev_addr;
  logic          have_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_ack <= '0;
      fs_age    <= '0;
      prev_addr <= '0;
      have_prev <= 1'b0;
    end else begin
      if (cpu_ack) since_ack <= CW'(1);
      else if (since_ack != '0 && since_ack != CW'(SAT)) since_ack <= since_ack + 1'b1;
      if (frame_start) fs_age <= '0;
      else if (fs_age != CW'(SAT)) fs_age <= fs_age + 1'b1;
      if (vid_valid) begin
        prev_addr <= vid_addr;
        have_prev <= 1'b1;
      end
    end
  end

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_we_n && !sram_oe_n));
  a_r2_write_in_cpu_turn: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> phase < TURN);
  a_r6_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);
  a_r6_ready_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> since_ack == CW'(ACC));
  a_r3_valid_phase: assert property (@(posedge clk) disable iff (!rst_n)
    vid_valid |-> phase == '0);
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_valid && have_prev && fs_age == CW'(SAT)) |-> vid_addr == prev_addr + AW'(2));
endmodule

bind double_pump_arbiter double_pump_arbiter_props #(.AW(AW), .SUB(SUB)) i_props (
  .clk(clk), .rst_n(rst_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
  .cpu_ack(cpu_ack), .cpu_ready(cpu_ready), .vid_valid(vid_valid),
  .vid_addr(vid_addr), .frame_start(frame_start), .phase(phase)
);

// File: tb/test_double_pump_arbiter.sv
module test_double_pump_arbiter;
  localparam int unsigned AW    = 10;
  localparam int unsigned SUB   = 4;
  localparam int unsigned VBASE = 10'h100;
  localparam int ACC  = 2 * SUB;
  localparam int TURN = 2 * ACC;
  localparam int PER  = 2 * TURN;
  localparam int NW   = 1 << AW;

  // {arrival phase[33:29], we[28], be[27:26], addr[25:16], data[15:0]}
  localparam logic [33:0] VEC [0:11] = '{
    {5'd3,  1'b1, 2'b11, 10'h010, 16'hA1B2},
    {5'd16, 1'b0, 2'b11, 10'h010, 16'h0000},
    {5'd31, 1'b1, 2'b10, 10'h010, 16'hCCDD},
    {5'd0,  1'b0, 2'b00, 10'h010, 16'h0000},
    {5'd20, 1'b1, 2'b01, 10'h011, 16'hEEFF},
    {5'd15, 1'b0, 2'b11, 10'h011, 16'h0000},
    {5'd7,  1'b1, 2'b00, 10'h012, 16'h1234},
    {5'd25, 1'b0, 2'b11, 10'h012, 16'h0000},
    {5'd9,  1'b0, 2'b11, 10'h3FF, 16'h0000},
    {5'd17, 1'b1, 2'b11, 10'h3FF, 16'h0F0F},
    {5'd30, 1'b0, 2'b11, 10'h3FF, 16'h0000},
    {5'd12, 1'b0, 2'b11, 10'h101, 16'h0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0, frame_start = 1'b0;
  logic [1:0] cpu_be = 2'b00;
  logic [AW-1:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic cpu_ack, cpu_ready, vid_valid;
  logic [15:0] cpu_rdata, sram_dout, sram_din;
  logic [AW-1:0] vid_addr, sram_addr;
  logic [31:0] vid_data;
  logic sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n;

  logic [15:0] mem [NW];
  logic [15:0] shadow [NW];
  int cyc = 0, checks = 0, failures = 0, fs_hits = 0, fs_skip = 0;
  bit done = 0, ackseen = 0, fs_arm = 0, saw_wrap = 0;
  logic [AW-1:0] vexp = AW'(VBASE);

  always #5 clk = ~clk;

  double_pump_arbiter #(.AW(AW), .SUB(SUB), .VBASE(VBASE)) i_double_pump_arbiter (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_be(cpu_be),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .frame_start(frame_start), .vid_valid(vid_valid),
    .vid_addr(vid_addr), .vid_data(vid_data), .sram_addr(sram_addr), .sram_dout(sram_dout),
    .sram_din(sram_din), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n));

  assign sram_din = (!sram_ce_n && !sram_oe_n) ? mem[sram_addr] : 16'hDEAD;

  always @(posedge clk) begin
    if (!sram_ce_n && !sram_we_n) begin
      if (!sram_ub_n) mem[sram_addr][15:8] <= sram_dout[15:8];
      if (!sram_lb_n) mem[sram_addr][7:0]  <= sram_dout[7:0];
    end
  end

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic int ph = cyc % PER;
      automatic bit fsapp = 0;
      if (!sram_we_n) begin
        chk(ph < TURN, "R2", "write strobe outside processor turn", ph, TURN);
        chk(sram_oe_n, "R9", "both strobes low", sram_oe_n, 1);
      end
      if (ph >= TURN) chk(!sram_ce_n && sram_we_n, "R2", "video turn ce/we",
                          {sram_ce_n, sram_we_n}, 2'b01);
      if (ph % ACC == 0 && !sram_ce_n)
        chk(sram_oe_n && sram_we_n, "R9", "setup cycle strobes", {sram_oe_n, sram_we_n}, 2'b11);
      if (ph == 0) ackseen = cpu_ack;
      if (ph < TURN && (!ackseen || ph >= ACC))
        chk(sram_ce_n, "R10", "idle processor slot enabled SRAM", sram_ce_n, 1);
      if (cpu_ack) chk(ph == 0, "R6", "ack phase", ph, 0);
      if (cpu_ready) chk(ph == ACC, "R6", "ready phase", ph, ACC);
      if (ph == 0 && cyc >= PER) chk(vid_valid, "R3", "missing video word", vid_valid, 1);
      if (vid_valid) begin
        chk(ph == 0, "R3", "valid phase", ph, 0);
        if (fs_arm) begin
          if (fs_skip == 0) begin vexp = AW'(VBASE); fs_arm = 0; fsapp = 1; end
          else fs_skip--;
        end
        chk(vid_addr == vexp, fsapp ? "R5" : "R4", "video address", vid_addr, vexp);
        chk(vid_data == {shadow[vexp], shadow[vexp + AW'(1)]}, "R3", "video data",
            vid_data, {shadow[vexp], shadow[vexp + AW'(1)]});
        if (fsapp && vid_addr == vexp) fs_hits++;
        if (!fsapp && vexp == '0 && vid_addr == '0) saw_wrap = 1;
        vexp = vexp + AW'(2);
      end
    end
  end

  task automatic do_op(input logic [33:0] v);
    automatic int arr = int'(v[33:29]);
    automatic int rc, lat;
    automatic logic [15:0] exp;
    while (cyc % PER != arr) @(negedge clk);
    cpu_req = 1; cpu_we = v[28]; cpu_be = v[27:26]; cpu_addr = v[25:16]; cpu_wdata = v[15:0];
    rc = cyc;
    do @(negedge clk); while (!cpu_ack);
    lat = cyc - rc;
    chk(lat == PER - arr, arr >= TURN ? "R7" : "R6", "acknowledge latency", lat, PER - arr);
    cpu_addr = ~v[25:16]; cpu_wdata = 16'h5555; cpu_be = ~v[27:26]; cpu_we = ~v[28];
    do @(negedge clk); while (!cpu_ready);
    chk(cyc % PER == ACC, "R6", "ready after ack", cyc % PER, ACC);
    if (v[28]) begin
      exp = shadow[v[25:16]];
      if (v[27]) exp[15:8] = v[15:8];
      if (v[26]) exp[7:0] = v[7:0];
      shadow[v[25:16]] = exp;
      chk(mem[v[25:16]] == exp, "R8", "byte-lane write result", mem[v[25:16]], exp);
    end else begin
      chk(cpu_rdata == shadow[v[25:16]], "R6", "read data", cpu_rdata, shadow[v[25:16]]);
    end
    cpu_req = 0;
  endtask

  task automatic pulse_fs(input int at);
    while (cyc % PER != at) @(negedge clk);
    fs_arm = 1; fs_skip = (at >= TURN) ? 1 : 0;
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
  endtask

  task automatic reset_check();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(sram_ce_n && sram_we_n && sram_oe_n, "R1", "SRAM strobes in reset",
        {sram_ce_n, sram_we_n, sram_oe_n}, 3'b111);
    chk(!cpu_ack && !cpu_ready && !vid_valid, "R1", "outputs in reset",
        {cpu_ack, cpu_ready, vid_valid}, 3'b000);
    vexp = AW'(VBASE); fs_arm = 0; ackseen = 0;
    #1 rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NW; i++) begin
      mem[i] = 16'(i * 16'h9E37) ^ 16'h5A5A;
      shadow[i] = mem[i];
    end
    reset_check();
    for (int i = 0; i < 12; i++) do_op(VEC[i]);
    pulse_fs(5);
    repeat (3 * PER) @(negedge clk);
    pulse_fs(20);
    repeat (4 * PER) @(negedge clk);
    chk(fs_hits == 2, "R5", "frame start rewinds", fs_hits, 2);
    repeat ((NW / 2 + 4) * PER) @(negedge clk);
    chk(saw_wrap, "R4", "address wrap observed", saw_wrap, 1);
    reset_check();
    repeat (2 * PER + 2) @(negedge clk);
    chk(fs_hits == 2 && !fs_arm, "R1", "restart from base verified by monitor", fs_arm, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule